// File: doc/BRIEF.md
# Audio Sample Word Unpacker

This block sits between a word prefetch buffer and an audio serializer. It holds one 32-bit memory word at a time and hands out one left/right sample pair whenever the serializer asks for one. How the word is cut into pairs depends on the packing mode: 8-bit or 16-bit values, mono or stereo. The byte order of the word is selectable. The most significant bit of every value can optionally be inverted, which converts between signed and offset-binary sample formats.

In a mono mode a single value is driven to both channels. In a stereo mode a left/right pair counts as one sample. The block also reports how many samples the current mode draws from each word, so that the buffer manager can count samples against a buffer size. Words enter through a valid/ready handshake. A new word is taken only once every sample of the held word has been consumed.

Top module: `pcm_word_unpacker`

## Requirements
- R1: While reset is held, `left_o` and `right_o` are zero, `smp_taken_o` is low and `word_ready_o` is high.
- R2: `smp_per_word_o` is 4 for mode 00, 2 for mode 01, 2 for mode 10 and 1 for mode 11.
- R3: A word is accepted on a clock edge where `word_valid_i` and `word_ready_o` are both high. `word_ready_o` then stays low until the cycle after the edge on which the last sample of that word is taken.
- R4: A request (`smp_req_i`) made while a word is held causes `smp_taken_o` to be high in the next cycle, with the new pair on `left_o`/`right_o`. A request made while no word is held gives no pulse and leaves both outputs unchanged.
- R5: Mode 00 (mono, 8-bit): sample i of a word is memory byte i. It is driven on both channels in the upper byte, and all lower bits are zero.
- R6: Mode 01 (stereo, 8-bit): sample i takes memory byte 2i as left and byte 2i+1 as right, each in the upper byte with the lower bits zero.
- R7: Mode 10 (mono, 16-bit): sample i is memory halfword i (bytes 2i and 2i+1), driven on both channels.
- R8: Mode 11 (stereo, 16-bit): the left channel takes the lower-addressed halfword (bytes 0 and 1) and the right channel takes bytes 2 and 3.
- R9: With `little_endian_i` = 0, memory byte a sits at word bits [31-8a -: 8], and the lower-addressed byte of a halfword is its MSB. With `little_endian_i` = 1, byte a sits at bits [8a +: 8], and the lower-addressed byte is the LSB.
- R10: With `sign_flip_i` = 1, bit 15 of the 16-bit value (the top output bit) is inverted on both channels. With 0 it is left unchanged.
- R11: For `OUT_W` > 16, the 16-bit value fills the top 16 output bits and the bits below are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid_i | input | 1 | Prefetch buffer offers a word |
| word_data_i | input | 32 | Offered memory word |
| word_ready_o | output | 1 | Block can accept a word |
| mode_i | input | 2 | Packing mode (00 mono8, 01 stereo8, 10 mono16, 11 stereo16) |
| little_endian_i | input | 1 | Byte order of the word: 0 big, 1 little |
| sign_flip_i | input | 1 | Invert the MSB of each value |
| smp_req_i | input | 1 | Serializer asks for the next pair |
| smp_per_word_o | output | 3 | Samples drawn from each word in the current mode |
| smp_taken_o | output | 1 | One-cycle pulse: a new pair is on the outputs |
| left_o | output | OUT_W | Left channel value |
| right_o | output | OUT_W | Right channel value |

## Verification
The bench builds two instances side by side from the same stimulus: one with `OUT_W` = 16 and one with `OUT_W` = 24. The 16-bit build puts the inverted sign bit on the very top output bit. The 24-bit build exposes the zero padding below the value and any misplaced shift of the value within the output. The bench walks every combination of mode, byte order and sign option. It keeps a second word pending while the first drains, so that back-pressure and the hand-over between words are exercised in every mode.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;

  localparam int WORD_W  = 32;
  localparam int VAL_W   = 16;
  localparam int LANES   = WORD_W / 8;
  localparam int LANE_AW = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_MONO8    = 2'b00,
    MODE_STEREO8  = 2'b01,
    MODE_MONO16   = 2'b10,
    MODE_STEREO16 = 2'b11
  } pcm_mode_e;

  // Samples one word yields in a given packing mode.
  function automatic logic [2:0] smp_per_word(input pcm_mode_e mode);
    case (mode)
      MODE_MONO8:    return 3'd4;
      MODE_STEREO16: return 3'd1;
      default:       return 3'd2;
    endcase
  endfunction

  // Byte at memory address addr inside the word, given the byte order.
  function automatic logic [7:0] byte_at(input logic [WORD_W-1:0] w,
                                         input logic [LANE_AW-1:0] addr,
                                         input logic le);
    logic [LANE_AW-1:0] lane;
    lane = le ? addr : ~addr;
    return w[{lane, 3'b000} +: 8];
  endfunction

  // Halfword hidx: the lower-addressed byte is MSB for big endian, LSB for little.
  function automatic logic [VAL_W-1:0] half_at(input logic [WORD_W-1:0] w,
                                               input logic hidx,
                                               input logic le);
    logic [7:0] first, second;
    first  = byte_at(w, {hidx, 1'b0}, le);
    second = byte_at(w, {hidx, 1'b1}, le);
    return le ? {second, first} : {first, second};
  endfunction

endpackage

// File: rtl/pcm_word_hold.sv
module pcm_word_hold
  import pcm_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              req_i,
  input  logic [2:0]        spw_i,
  output logic              word_ready_o,
  output logic [WORD_W-1:0] word_q,
  output logic [LANE_AW-1:0] idx_q,
  output logic              full_q,
  output logic              load_ev,
  output logic              take_ev,
  output logic              last_ev
);

  assign word_ready_o = !full_q;
  assign load_ev      = word_valid_i && !full_q;
  assign take_ev      = req_i && full_q;
  assign last_ev      = ({1'b0, idx_q} + 3'd1) >= spw_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (load_ev) begin
      word_q <= word_i;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (take_ev) begin
      if (last_ev) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !(take_ev && last_ev) |=> full_q && $stable(word_q)); // R3
  AST_DRAIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && last_ev |=> !full_q && word_ready_o); // R3
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> full_q && (idx_q == '0)); // R3

endmodule

// File: rtl/pcm_pair_fmt.sv
module pcm_pair_fmt
  import pcm_unpack_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [LANE_AW-1:0] idx_i,
  input  pcm_mode_e          mode_i,
  input  logic               le_i,
  input  logic               flip_i,
  output logic [OUT_W-1:0]   left_o,
  output logic [OUT_W-1:0]   right_o
);

  localparam int PAD_W = OUT_W - VAL_W;

  logic [VAL_W-1:0] l_raw, r_raw, l_val, r_val;

  always_comb begin
    case (mode_i)
      MODE_MONO8: begin
        l_raw = {byte_at(word_i, idx_i, le_i), 8'h00};
        r_raw = l_raw;
      end
      MODE_STEREO8: begin
        l_raw = {byte_at(word_i, {idx_i[0], 1'b0}, le_i), 8'h00};
        r_raw = {byte_at(word_i, {idx_i[0], 1'b1}, le_i), 8'h00};
      end
      MODE_MONO16: begin
        l_raw = half_at(word_i, idx_i[0], le_i);
        r_raw = l_raw;
      end
      default: begin
        l_raw = half_at(word_i, 1'b0, le_i);
        r_raw = half_at(word_i, 1'b1, le_i);
      end
    endcase
    l_val = {l_raw[VAL_W-1] ^ flip_i, l_raw[VAL_W-2:0]};
    r_val = {r_raw[VAL_W-1] ^ flip_i, r_raw[VAL_W-2:0]};
  end

  generate
    if (PAD_W == 0) begin : g_exact
      assign left_o  = l_val;
      assign right_o = r_val;
    end else begin : g_pad
      assign left_o  = {l_val, {PAD_W{1'b0}}};
      assign right_o = {r_val, {PAD_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/pcm_word_unpacker.sv
module pcm_word_unpacker
  import pcm_unpack_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid_i,
  input  logic [31:0]      word_data_i,
  output logic             word_ready_o,
  input  logic [1:0]       mode_i,
  input  logic             little_endian_i,
  input  logic             sign_flip_i,
  input  logic             smp_req_i,
  output logic [2:0]       smp_per_word_o,
  output logic             smp_taken_o,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o
);

  pcm_mode_e          mode;
  logic [WORD_W-1:0]  hold_word;
  logic [LANE_AW-1:0] hold_idx;
  logic               hold_full, load_ev, take_ev, last_ev;
  logic [OUT_W-1:0]   fmt_l, fmt_r;

  assign mode           = pcm_mode_e'(mode_i);
  assign smp_per_word_o = smp_per_word(mode);

  pcm_word_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid_i (word_valid_i),
    .word_i       (word_data_i),
    .req_i        (smp_req_i),
    .spw_i        (smp_per_word_o),
    .word_ready_o (word_ready_o),
    .word_q       (hold_word),
    .idx_q        (hold_idx),
    .full_q       (hold_full),
    .load_ev      (load_ev),
    .take_ev      (take_ev),
    .last_ev      (last_ev)
  );

  pcm_pair_fmt #(.OUT_W(OUT_W)) u_fmt (
    .word_i  (hold_word),
    .idx_i   (hold_idx),
    .mode_i  (mode),
    .le_i    (little_endian_i),
    .flip_i  (sign_flip_i),
    .left_o  (fmt_l),
    .right_o (fmt_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_o      <= '0;
      right_o     <= '0;
      smp_taken_o <= 1'b0;
    end else begin
      smp_taken_o <= take_ev;
      if (take_ev) begin
        left_o  <= fmt_l;
        right_o <= fmt_r;
      end
    end
  end

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> smp_taken_o); // R4
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req_i && !hold_full |=> !smp_taken_o && $stable(left_o) && $stable(right_o)); // R4
  AST_MONO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && !mode_i[0] |=> left_o == right_o); // R5
  AST_BYTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && !mode_i[1] |=> (left_o[OUT_W-9:0] == '0) && (right_o[OUT_W-9:0] == '0)); // R6
  AST_PER_WORD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(smp_per_word_o) == 1); // R2

endmodule

// File: tb/pcm_word_unpacker_tb.sv
module pcm_word_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic [1:0]  mode = 2'b00;
  logic        le = 1'b0;
  logic        flip = 1'b0;
  logic        req = 1'b0;

  logic        ready_a, taken_a, ready_b, taken_b;
  logic [2:0]  spw_a, spw_b;
  logic [15:0] left_a, right_a;
  logic [23:0] left_b, right_b;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcm_word_unpacker #(.OUT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid), .word_data_i(word_data),
    .word_ready_o(ready_a), .mode_i(mode), .little_endian_i(le), .sign_flip_i(flip),
    .smp_req_i(req), .smp_per_word_o(spw_a), .smp_taken_o(taken_a),
    .left_o(left_a), .right_o(right_a));

  pcm_word_unpacker #(.OUT_W(24)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid), .word_data_i(word_data),
    .word_ready_o(ready_b), .mode_i(mode), .little_endian_i(le), .sign_flip_i(flip),
    .smp_req_i(req), .smp_per_word_o(spw_b), .smp_taken_o(taken_b),
    .left_o(left_b), .right_o(right_b));

  // Reference model state
  bit          m_full = 1'b0;
  logic [31:0] m_word = '0;
  int          m_idx = 0;
  bit          m_taken = 1'b0;
  logic [15:0] m_l = '0, m_r = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int mem_byte(input logic [31:0] w, input int a, input bit little);
    int sh;
    sh = little ? 8 * a : 8 * (3 - a);
    return int'((w >> sh) & 32'hFF);
  endfunction

  function automatic logic [15:0] mem_half(input logic [31:0] w, input int h, input bit little);
    int lo_addr, hi_addr;
    lo_addr = mem_byte(w, 2 * h, little);
    hi_addr = mem_byte(w, 2 * h + 1, little);
    if (little) return 16'(hi_addr * 256 + lo_addr);
    return 16'(lo_addr * 256 + hi_addr);
  endfunction

  function automatic string tag_of();
    string s;
    case (mode)
      2'b00: s = "R5";
      2'b01: s = "R6";
      2'b10: s = "R7";
      default: s = "R8";
    endcase
    if (le) s = {s, " R9"};
    else s = {s, " R9(big)"};
    if (flip) s = {s, " R10"};
    return s;
  endfunction

  function automatic int exp_spw();
    if (mode == 2'b00) return 4;
    if (mode == 2'b11) return 1;
    return 2;
  endfunction

  task automatic compare();
    string t;
    t = tag_of();
    chk(ready_a == !m_full && ready_b == !m_full, "R3 ready", {31'd0, ready_a}, {31'd0, !m_full});
    chk(taken_a == m_taken && taken_b == m_taken, "R4 taken", {31'd0, taken_a}, {31'd0, m_taken});
    chk(int'(spw_a) == exp_spw() && int'(spw_b) == exp_spw(), "R2 per-word", {29'd0, spw_a}, exp_spw());
    chk(left_a == m_l, {t, " left"}, {16'd0, left_a}, {16'd0, m_l});
    chk(right_a == m_r, {t, " right"}, {16'd0, right_a}, {16'd0, m_r});
    chk(left_b == {m_l, 8'h00}, {t, " R11 wide left"}, {8'd0, left_b}, {8'd0, m_l, 8'h00});
    chk(right_b == {m_r, 8'h00}, {t, " R11 wide right"}, {8'd0, right_b}, {8'd0, m_r, 8'h00});
  endtask

  // Drive one cycle at a negedge, advance the model, compare at the next negedge.
  task automatic cycle(input bit v, input logic [31:0] w, input bit rq);
    bit accept, take;
    int spw;
    logic [15:0] l, r;
    word_valid = v;
    word_data  = w;
    req        = rq;
    spw    = exp_spw();
    accept = v && !m_full;
    take   = rq && m_full;
    if (take) begin
      case (mode)
        2'b00: begin l = 16'(mem_byte(m_word, m_idx, le) * 256); r = l; end
        2'b01: begin
          l = 16'(mem_byte(m_word, 2 * m_idx, le) * 256);
          r = 16'(mem_byte(m_word, 2 * m_idx + 1, le) * 256);
        end
        2'b10: begin l = mem_half(m_word, m_idx, le); r = l; end
        default: begin l = mem_half(m_word, 0, le); r = mem_half(m_word, 1, le); end
      endcase
      if (flip) begin l = l ^ 16'h8000; r = r ^ 16'h8000; end
      m_l = l;
      m_r = r;
    end
    m_taken = take;
    if (accept) begin
      m_full = 1'b1; m_word = w; m_idx = 0;
    end else if (take) begin
      if (m_idx + 1 >= spw) begin m_full = 1'b0; m_idx = 0; end
      else m_idx++;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk(left_a == 16'd0 && left_b == 24'd0, "R1 left", {8'd0, left_b}, 32'd0);
    chk(right_a == 16'd0 && right_b == 24'd0, "R1 right", {8'd0, right_b}, 32'd0);
    chk(!taken_a && !taken_b, "R1 taken", {31'd0, taken_a}, 32'd0);
    chk(ready_a && ready_b, "R1 ready", {31'd0, ready_a}, 32'd1);
    rst_n = 1'b1;
    // R4: request with no word held
    cycle(1'b0, 32'h0, 1'b1);
    cycle(1'b0, 32'h0, 1'b1);
    for (int md = 0; md < 4; md++) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] wa, wb;
          mode = md[1:0];
          le   = e[0];
          flip = s[0];
          seed = seed * 32'd1664525 + 32'd1013904223;
          wa   = seed;
          seed = seed * 32'd1664525 + 32'd1013904223;
          wb   = seed;
          cycle(1'b1, wa, 1'b0);
          // R3: second word offered while the first drains
          for (int k = 0; k < exp_spw() + 3; k++) begin
            cycle(1'b1, wb, (k % 3) != 2);
            if (!m_full || m_word == wb) break;
          end
          for (int k = 0; k < 7; k++) cycle(1'b0, 32'h0, (k % 2) == 0 || k > 3);
        end
      end
    end
    // R8 R9: known pattern, stereo 16-bit, both byte orders
    mode = 2'b11; le = 1'b0; flip = 1'b0;
    cycle(1'b1, 32'h1122_3344, 1'b0);
    cycle(1'b0, 32'h0, 1'b1);
    chk(left_a == 16'h1122 && right_a == 16'h3344, "R8 R9 big pattern", {left_a, right_a}, 32'h1122_3344);
    le = 1'b1;
    cycle(1'b1, 32'h1122_3344, 1'b0);
    cycle(1'b0, 32'h0, 1'b1);
    chk(left_a == 16'h3344 && right_a == 16'h1122, "R8 R9 little pattern", {left_a, right_a}, 32'h3344_1122);
    // R5 R10: mono 8-bit byte 0 with sign inversion
    mode = 2'b00; le = 1'b0; flip = 1'b1;
    cycle(1'b1, 32'hA5B6_C7D8, 1'b0);
    cycle(1'b0, 32'h0, 1'b1);
    chk(left_a == 16'h2500 && right_a == 16'h2500, "R5 R10 pattern", {left_a, right_a}, 32'h2500_2500);
    repeat (4) cycle(1'b0, 32'h0, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule